// File: doc/BRIEF.md
# Radix-2-squared feedback butterfly stage pair

This block is one stage pair of a streaming pipelined FFT built from single-path delay-feedback butterflies. One complex sample enters on every clock and one complex sample leaves on every clock. Frames of N samples follow each other with no gap. The first butterfly pairs samples N/2 apart. The second pairs samples N/4 apart and rotates some of its inputs by -j. Together they produce the radix-4 decomposition of the frame with radix-2 adders only. The output stream goes to the next nontrivial twiddle multiplier, which lies outside this block.

A single binary counter sequences both butterflies. Pulsing `start_i` with the first sample of a frame restarts this counter. Each butterfly spends half of its window loading its feedback register. In the other half it computes a 2-point sum and difference. The sum goes forward at once. The difference is stored and sent forward during the next load half. Every adder widens its result by one bit, so the output is DW+2 bits wide and can never wrap.

Top module: `r22_sdf_pair`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and both output words are 0. After reset, `out_valid_o` stays 0 until the first `start_i` pulse, whatever the input data.
- R2: The sample taken with `start_i`=1 becomes index n=0 of a frame, from any counter state. `out_valid_o` reads 0 in the cycle after that clock edge.
- R3: `out_valid_o` first reads 1 after exactly 3N/4+1 clock edges, counted from the edge that takes the start sample.
- R4: Write output position s (0..N-1) within a frame as s = k1·N/2 + k2·N/4 + n3. The output at s is the sum over n1,n2 in {0,1} of x[n1·N/2 + n2·N/4 + n3] · (-1)^(n1·k1 + n2·k2) · (-j)^(n2·k1).
- R5: Consecutive frames stream back to back. `out_valid_o` stays 1 until the next `start_i`. Each frame's outputs depend only on that frame's samples.
- R6: The -j rotation, (re,im) → (im,-re), acts only on the terms with n1-group k1=1 and n2=1. These are the last quarter of the second butterfly's input window.
- R7: Full-scale inputs produce exact results in DW+2 bits with no wrap. For example, a constant frame of (-2^(DW-1), -2^(DW-1)) gives -2^(DW+1) on both parts at s=0.
- R8: Multiply each output by e^(-j2π·n3·(k1+2k2)/N), then take an N/4-point DFT over n3 for each (k1,k2). The result is the N-point DFT bin X[k1 + 2·k2 + 4·k3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the current input sample as frame index 0 |
| in_re_i | input | DW | Input sample, real part, two's complement |
| in_im_i | input | DW | Input sample, imaginary part, two's complement |
| out_re_o | output | DW+2 | Output sample, real part |
| out_im_o | output | DW+2 | Output sample, imaginary part |
| out_valid_o | output | 1 | Output stream is aligned to frame position s=0 onward |

## Verification
Each input pattern exposes a different kind of error:
- Impulses at chosen indices isolate single terms of the sum. An impulse at n=0 shows whether the samples are aligned. An impulse at n=5 shows whether the n3 offset is right. Impulses at n=12 and n=14 show whether the -j rotation lands in the correct quarter, with the correct sign.
- Constant and alternating full-scale frames reach the extreme sums. A missing growth bit, or a negation that wraps, shows up here.
- A ramp and pseudo-random frames exercise every term at once. They are also checked against a direct N-point DFT after the external twiddles are applied.
- A second run starts partway through a counter cycle, to show that `start_i` realigns the frame.

// File: rtl/r22_pkg.sv
package r22_pkg;

  typedef enum logic {
    BF_LOAD = 1'b0,
    BF_CALC = 1'b1
  } bf_phase_e;

  // cycles from the start-sample edge until the first aligned output edge
  function automatic int fill_latency(input int n);
    return (3 * n) / 4 + 1;
  endfunction

endpackage

// File: rtl/r22_delay.sv
module r22_delay #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < D; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[D-1];

endmodule

// File: rtl/r22_bf.sv
module r22_bf
  import r22_pkg::*;
#(
  parameter int W_IN  = 12,
  parameter int W_OUT = 13,
  parameter int DIST  = 8,
  parameter int ROT   = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  bf_phase_e               phase_i,
  input  logic                    rot_i,
  input  logic signed [W_IN-1:0]  in_re_i,
  input  logic signed [W_IN-1:0]  in_im_i,
  output logic signed [W_OUT-1:0] out_re_o,
  output logic signed [W_OUT-1:0] out_im_o
);

  localparam int EXT = W_OUT - W_IN;

  logic signed [W_OUT-1:0] x_re, x_im, b_re, b_im;
  logic signed [W_OUT-1:0] a_re, a_im, d_re, d_im;
  logic        [2*W_OUT-1:0] dly_d, dly_q;

  assign x_re = {{EXT{in_re_i[W_IN-1]}}, in_re_i};
  assign x_im = {{EXT{in_im_i[W_IN-1]}}, in_im_i};

  generate
    if (ROT != 0) begin : g_rot
      // multiply by -j: (re, im) -> (im, -re)
      assign b_re = rot_i ? x_im  : x_re;
      assign b_im = rot_i ? -x_re : x_im;
    end else begin : g_pass
      logic unused_rot;
      assign unused_rot = rot_i;
      assign b_re = x_re;
      assign b_im = x_im;
    end
  endgenerate

  r22_delay #(.W(2 * W_OUT), .D(DIST)) u_fb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dly_d),
    .q_o   (dly_q)
  );

  assign a_re = dly_q[2*W_OUT-1:W_OUT];
  assign a_im = dly_q[W_OUT-1:0];

  always_comb begin
    if (phase_i == BF_CALC) begin
      out_re_o = a_re + b_re;
      out_im_o = a_im + b_im;
      d_re     = a_re - b_re;
      d_im     = a_im - b_im;
    end else begin
      out_re_o = a_re;
      out_im_o = a_im;
      d_re     = b_re;
      d_im     = b_im;
    end
  end

  assign dly_d = {d_re, d_im};

endmodule

// File: rtl/r22_ctrl.sv
module r22_ctrl
  import r22_pkg::*;
#(
  parameter int N = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output bf_phase_e ph1_o,
  output bf_phase_e ph2_o,
  output logic      rot2_o,
  output logic      vld_o
);

  localparam int L   = $clog2(N);
  localparam int LAT = fill_latency(N);
  localparam int FW  = $clog2(LAT + 1) + 1;

  logic [L-1:0]  cnt_q, cur, idx_q;
  logic [FW-1:0] fill_q;
  logic          vld_q;

  assign cur = start_i ? '0 : cnt_q;

  // idx_q is the count of the sample now in the inter-butterfly register
  assign ph1_o  = bf_phase_e'(cur[L-1]);
  assign ph2_o  = bf_phase_e'(idx_q[L-2]);
  assign rot2_o = ~idx_q[L-1] & idx_q[L-2];
  assign vld_o  = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cur + 1'b1;
      idx_q <= cur;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else if (start_i) begin
      fill_q <= FW'(1);
      vld_q  <= 1'b0;
    end else if (!vld_q && fill_q != '0) begin
      if (fill_q == FW'(LAT)) vld_q  <= 1'b1;
      else                    fill_q <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/r22_sdf_pair.sv
module r22_sdf_pair
  import r22_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [DW-1:0] in_re_i,
  input  logic signed [DW-1:0] in_im_i,
  output logic signed [DW+1:0] out_re_o,
  output logic signed [DW+1:0] out_im_o,
  output logic                 out_valid_o
);

  localparam int W1 = DW + 1;
  localparam int W2 = DW + 2;

  bf_phase_e ph1, ph2;
  logic      rot2;

  logic signed [W1-1:0] b1_re, b1_im, z1_re_q, z1_im_q;
  logic signed [W2-1:0] b2_re, b2_im;

  r22_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ph1_o  (ph1),
    .ph2_o  (ph2),
    .rot2_o (rot2),
    .vld_o  (out_valid_o)
  );

  r22_bf #(.W_IN(DW), .W_OUT(W1), .DIST(N / 2), .ROT(0)) u_bf1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (ph1),
    .rot_i   (1'b0),
    .in_re_i (in_re_i),
    .in_im_i (in_im_i),
    .out_re_o(b1_re),
    .out_im_o(b1_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z1_re_q <= '0;
      z1_im_q <= '0;
    end else begin
      z1_re_q <= b1_re;
      z1_im_q <= b1_im;
    end
  end

  r22_bf #(.W_IN(W1), .W_OUT(W2), .DIST(N / 4), .ROT(1)) u_bf2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (ph2),
    .rot_i   (rot2),
    .in_re_i (z1_re_q),
    .in_im_i (z1_im_q),
    .out_re_o(b2_re),
    .out_im_o(b2_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_re_o <= '0;
      out_im_o <= '0;
    end else begin
      out_re_o <= b2_re;
      out_im_o <= b2_im;
    end
  end

endmodule

// File: rtl/r22_sdf_pair_chk.sv
module r22_sdf_pair_chk
  import r22_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic signed [DW-1:0] in_re_i,
  input logic signed [DW-1:0] in_im_i,
  input logic signed [DW+1:0] out_re_o,
  input logic signed [DW+1:0] out_im_o,
  input logic                 out_valid_o
);

  localparam int LAT  = fill_latency(N);
  localparam int SW   = $clog2(LAT + 2) + 1;
  localparam int ZMAX = 2 * N + 4;
  localparam int ZW   = $clog2(ZMAX + 1) + 1;

  logic [SW-1:0] since_q;
  logic [ZW-1:0] zrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (start_i) since_q <= SW'(1);
    else if (since_q != '0 && since_q != SW'(LAT + 2)) since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zrun_q <= '0;
    else if (in_re_i != '0 || in_im_i != '0) zrun_q <= '0;
    else if (zrun_q != ZW'(ZMAX)) zrun_q <= zrun_q + 1'b1;
  end

  AST_START_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !out_valid_o); // R2

  AST_FILL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> since_q == SW'(LAT + 1)); // R3

  AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !start_i) |=> out_valid_o); // R5

  AST_ZERO_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zrun_q == ZW'(ZMAX) |-> (out_re_o == '0 && out_im_o == '0)); // R5

endmodule

bind r22_sdf_pair r22_sdf_pair_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/tb_r22_sdf_pair.sv
module tb_r22_sdf_pair;

  localparam int  N    = 16;
  localparam int  DW   = 12;
  localparam int  LAT  = 3 * N / 4 + 1;
  localparam int  NV   = 10;
  localparam int  CAPN = 2 * NV * N + 64;
  localparam real PI   = 3.14159265358979;

  // kind: 0 impulse at pos, 1 constant, 2 alternating a / ~a, 3 ramp, 4 pseudo-random (seed=pos)
  typedef struct packed {
    logic [2:0]         kind;
    logic [7:0]         pos;
    logic signed [15:0] a_re;
    logic signed [15:0] a_im;
    logic               dc_ok;
    logic signed [15:0] dc_re;
    logic signed [15:0] dc_im;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'd0,   16'sd300,   -16'sd150, 1'b1, 16'sd300,   -16'sd150},
    '{3'd0, 8'd5,   16'sd1000,  16'sd0,    1'b1, 16'sd0,     16'sd0},
    '{3'd0, 8'd12,  16'sd500,   16'sd700,  1'b1, 16'sd500,   16'sd700},
    '{3'd0, 8'd14,  -16'sd2048, 16'sd2047, 1'b1, 16'sd0,     16'sd0},
    '{3'd1, 8'd0,   16'sd2047,  16'sd2047, 1'b1, 16'sd8188,  16'sd8188},
    '{3'd1, 8'd0,   -16'sd2048, -16'sd2048,1'b1, -16'sd8192, -16'sd8192},
    '{3'd2, 8'd0,   -16'sd2048, 16'sd2047, 1'b1, -16'sd8192, 16'sd8188},
    '{3'd3, 8'd0,   -16'sd800,  16'sd600,  1'b1, -16'sd800,  16'sd1512},
    '{3'd4, 8'd7,   16'sd0,     16'sd0,    1'b0, 16'sd0,     16'sd0},
    '{3'd4, 8'd99,  16'sd0,     16'sd0,    1'b0, 16'sd0,     16'sd0}
  };

  logic                 clk = 1'b0;
  logic                 rst_ni;
  logic                 start_i;
  logic signed [DW-1:0] in_re_i, in_im_i;
  logic signed [DW+1:0] out_re_o, out_im_o;
  logic                 out_valid_o;

  always #10 clk = ~clk;

  r22_sdf_pair #(.N(N), .DW(DW)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .in_re_i    (in_re_i),
    .in_im_i    (in_im_i),
    .out_re_o   (out_re_o),
    .out_im_o   (out_im_o),
    .out_valid_o(out_valid_o)
  );

  int xr [NV][N];
  int xi [NV][N];
  int cr [CAPN];
  int ci [CAPN];
  int cap, steps, first_vld, vld_at1;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int re, input int im, input bit st);
    @(negedge clk);
    if (steps > 0 && out_valid_o) begin
      if (first_vld < 0) first_vld = steps;
      if (cap < CAPN) begin
        cr[cap] = int'(out_re_o);
        ci[cap] = int'(out_im_o);
      end
      cap++;
    end
    if (steps == 1) vld_at1 = int'(out_valid_o);
    in_re_i = DW'(re);
    in_im_i = DW'(im);
    start_i = st;
    steps++;
  endtask

  task automatic build_frames();
    for (int f = 0; f < NV; f++) begin
      int unsigned st;
      st = int'(VEC[f].pos);
      for (int n = 0; n < N; n++) begin
        case (VEC[f].kind)
          3'd0: begin
            xr[f][n] = (n == int'(VEC[f].pos)) ? int'(VEC[f].a_re) : 0;
            xi[f][n] = (n == int'(VEC[f].pos)) ? int'(VEC[f].a_im) : 0;
          end
          3'd1: begin
            xr[f][n] = int'(VEC[f].a_re);
            xi[f][n] = int'(VEC[f].a_im);
          end
          3'd2: begin
            xr[f][n] = (n % 2 == 0) ? int'(VEC[f].a_re) : -1 - int'(VEC[f].a_re);
            xi[f][n] = (n % 2 == 0) ? int'(VEC[f].a_im) : -1 - int'(VEC[f].a_im);
          end
          3'd3: begin
            xr[f][n] = int'(VEC[f].a_re) + 100 * n;
            xi[f][n] = int'(VEC[f].a_im) - 37 * n;
          end
          default: begin
            st = st * 32'd1103515245 + 32'd12345;
            xr[f][n] = int'((st >> 16) & 32'd4095) - 2048;
            st = st * 32'd1103515245 + 32'd12345;
            xi[f][n] = int'((st >> 16) & 32'd4095) - 2048;
          end
        endcase
      end
    end
  endtask

  // expected output at frame position s, from the R4 formula
  task automatic ref_b(input int f, input int s, output int re, output int im);
    int k1, k2, n3, tr, ti, t;
    k1 = (s / (N / 2)) % 2;
    k2 = (s / (N / 4)) % 2;
    n3 = s % (N / 4);
    re = 0;
    im = 0;
    for (int n1 = 0; n1 < 2; n1++) begin
      for (int n2 = 0; n2 < 2; n2++) begin
        tr = xr[f][n1 * N / 2 + n2 * N / 4 + n3];
        ti = xi[f][n1 * N / 2 + n2 * N / 4 + n3];
        if (n2 == 1 && k1 == 1) begin
          t  = tr;
          tr = ti;
          ti = -t;
        end
        if (((n1 & k1) ^ (n2 & k2)) != 0) begin
          tr = -tr;
          ti = -ti;
        end
        re += tr;
        im += ti;
      end
    end
  endtask

  task automatic check_frame(input int f, input int base);
    int nbad, bad_s, act, exp, er, ei;
    nbad  = 0;
    bad_s = 0;
    act   = 0;
    exp   = 0;
    for (int s = 0; s < N; s++) begin
      ref_b(f, s, er, ei);
      if (cr[base + s] != er || ci[base + s] != ei) begin
        if (nbad == 0) begin
          bad_s = s;
          act   = (cr[base + s] != er) ? cr[base + s] : ci[base + s];
          exp   = (cr[base + s] != er) ? er : ei;
        end
        nbad++;
      end
    end
    chk(nbad == 0, (VEC[f].kind == 3'd0 && VEC[f].pos >= 8'd12) ? "R6" : "R4",
        $sformatf("frame %0d position %0d", f, bad_s), act, exp);
    if (VEC[f].dc_ok) begin
      chk(cr[base] == int'(VEC[f].dc_re) && ci[base] == int'(VEC[f].dc_im),
          (VEC[f].kind == 3'd1 || VEC[f].kind == 3'd2) ? "R7" : "R4",
          $sformatf("frame %0d s=0 re", f), cr[base], int'(VEC[f].dc_re));
    end
  endtask

  // R8: twiddles plus N/4-point DFT over n3 reproduce the N-point DFT
  task automatic dft_check(input int f, input int base);
    real maxe, xre, xim, yre, yim, th, e;
    int  k1, k2, s;
    maxe = 0.0;
    for (int k = 0; k < N; k++) begin
      xre = 0.0; xim = 0.0; yre = 0.0; yim = 0.0;
      for (int n = 0; n < N; n++) begin
        th  = 2.0 * PI * real'(n * k) / real'(N);
        xre += real'(xr[f][n]) * $cos(th) + real'(xi[f][n]) * $sin(th);
        xim += real'(xi[f][n]) * $cos(th) - real'(xr[f][n]) * $sin(th);
      end
      k1 = k % 2;
      k2 = (k / 2) % 2;
      for (int n3 = 0; n3 < N / 4; n3++) begin
        s   = k1 * N / 2 + k2 * N / 4 + n3;
        th  = 2.0 * PI * real'(n3 * k) / real'(N);
        yre += real'(cr[base + s]) * $cos(th) + real'(ci[base + s]) * $sin(th);
        yim += real'(ci[base + s]) * $cos(th) - real'(cr[base + s]) * $sin(th);
      end
      e = (xre - yre) * (xre - yre) + (xim - yim) * (xim - yim);
      if (e > maxe) maxe = e;
    end
    chk(maxe < 1.0e-6, "R8", $sformatf("frame %0d DFT error x1e6", f), int'(maxe * 1.0e6), 0);
  endtask

  task automatic run_seq(input int f0, input int nf);
    cap       = 0;
    steps     = 0;
    first_vld = -1;
    vld_at1   = 1;
    for (int f = f0; f < f0 + nf; f++)
      for (int n = 0; n < N; n++) tick(xr[f][n], xi[f][n], (f == f0) && (n == 0));
    for (int k = 0; k < LAT + 2; k++) tick(0, 0, 1'b0);
    chk(vld_at1 == 0, "R2", "valid one cycle after start", vld_at1, 0);
    chk(first_vld == LAT + 1, "R3", "first valid step", first_vld, LAT + 1);
    chk(cap >= nf * N, "R5", "contiguous valid outputs", cap, nf * N);
    for (int f = f0; f < f0 + nf; f++) check_frame(f, (f - f0) * N);
  endtask

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    in_re_i = '0;
    in_im_i = '0;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0, "R1", "valid in reset", int'(out_valid_o), 0);
    chk(out_re_o == '0 && out_im_o == '0, "R1", "output in reset", int'(out_re_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    build_frames();

    // R1: no start yet, valid must stay low under busy input
    cap   = 0;
    steps = 0;
    first_vld = -1;
    for (int k = 0; k < 3 * N; k++) tick(700 - 40 * k, -300 + 25 * k, 1'b0);
    chk(cap == 0, "R1", "valid samples before first start", cap, 0);

    // main table walk, all frames back to back
    run_seq(0, NV);

    // R6 hand values for impulse (500,700) at n=12
    chk(cr[2 * N + N / 2] == -700 && ci[2 * N + N / 2] == 500, "R6",
        "impulse n=12 at s=N/2 re", cr[2 * N + N / 2], -700);
    chk(cr[2 * N + 3 * N / 4] == 700 && ci[2 * N + 3 * N / 4] == -500, "R6",
        "impulse n=12 at s=3N/4 re", cr[2 * N + 3 * N / 4], 700);
    dft_check(7, 7 * N);
    dft_check(8, 8 * N);

    // R2: restart while the counter sits mid-frame
    run_seq(8, 2);
    dft_check(9, N);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule